// File: doc/BRIEF.md
# Serial Display Command Decoder

This block sits behind a three-wire, write-only serial link made up of an active-low select, a shift clock and a data line. It puts the incoming bits together into bytes, least significant bit first. The first byte of a transfer is decoded as a command. Any bytes that follow are routed as write strobes, each with its address and data, to three display memories:

- a 16-entry 8-bit character-code store;
- an 8-entry glyph-pattern store, five 7-bit columns per glyph;
- a 16-entry 2-bit symbol store.

The same command byte can instead update one of the small control registers that a display scanner reads: a static 2-bit port, a 3-bit duty code, a 3-bit digit-count code, a 2-bit light mode and a test flag.

The select, shift clock and data lines are brought into the system clock domain through synchroniser stages, and edges are detected there. A memory-write command leaves the decoder in a data mode. In that mode every further byte produces a one-cycle strobe and advances the address. In the glyph store, the address advances only after every fifth column byte.

Top module: `vfd_cmd_decoder`

## Requirements
- R1: Bits are taken on each rising shift-clock edge while `cs_ni` is low, first bit into byte bit 0. Shift-clock edges while `cs_ni` is high have no effect on strobes or registers.
- R2: A first byte whose bits 7..4 are 0001 selects character-code writes at the address in bits 3..0. Each following byte produces a `ccode_we_o` strobe carrying the full byte. The address then increments, wrapping from 15 to 0.
- R3: A first byte whose bits 7..4 are 0011 selects symbol writes at the address in bits 3..0. Each following byte produces a `sym_we_o` strobe carrying bits 1..0 of the byte. The address wraps from 15 to 0.
- R4: A first byte whose bits 7..4 are 0010 selects glyph writes at the address in bits 2..0. The next five bytes are columns 0..4 (`glyph_col_o`), with bits 6..0 as rows and bit 7 dropped. After column 4 the glyph address increments, wrapping from 7 to 0.
- R5: Bits 7..4 = 0100 sets `port_o[0]` from bit 0 and `port_o[1]` from bit 1.
- R6: Bits 7..4 = 0101 loads `duty_o` from bits 2..0, and bits 7..4 = 0110 loads `digits_o` from bits 2..0. Bit 3 is ignored in both.
- R7: Bits 7..4 = 0111 loads `light_o` from bits 1..0 (bit 0 = all off, bit 1 = all on).
- R8: A byte 1000_x000 (bit 3 ignored) clears `test_o`. A 1000 byte with any of bits 2..0 set leaves it unchanged. Control commands never enter data mode, so the next byte is decoded as a command.
- R9: A byte whose bits 7..4 match no command changes no output and produces no strobe. The decoder stays in command mode.
- R10: While `rst_ni` is low, the decoder is held in its reset state:
  - `port_o` = 0, `duty_o` = 0, `digits_o` = 0;
  - `light_o` = 01 (all off), `test_o` = 1;
  - all three memory addresses are 0, no strobe is active, and the decoder is in command mode.
- R11: A rise of `cs_ni` in the middle of a byte discards the partial byte but keeps the data mode and address. A rise on a byte boundary returns the decoder to command mode.
- R12: Every strobe lasts one cycle, and no two of the three strobes are ever active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial shift clock, sampled on rise |
| sdat_i | input | 1 | Serial data |
| ccode_we_o | output | 1 | Character-code write strobe |
| ccode_addr_o | output | 4 | Character-code address |
| ccode_data_o | output | 8 | Character code |
| glyph_we_o | output | 1 | Glyph column write strobe |
| glyph_addr_o | output | 3 | Glyph address |
| glyph_col_o | output | 3 | Column index 0..4 |
| glyph_data_o | output | 7 | Column row bits |
| sym_we_o | output | 1 | Symbol write strobe |
| sym_addr_o | output | 4 | Symbol address |
| sym_data_o | output | 2 | Symbol bits |
| port_o | output | 2 | Static output port |
| duty_o | output | 3 | Duty code |
| digits_o | output | 3 | Digit-count code |
| light_o | output | 2 | Light mode {all on, all off} |
| test_o | output | 1 | Test flag |

## Verification
A strobe, or a control-register update, is due SYNC_STAGES+2 system cycles after the raw shift-clock rise that carries the eighth bit: the result passes through the synchroniser stages, the edge detector, the byte-valid register and the output register. The bench holds each shift-clock phase for eight system cycles, so every strobe arrives before the next bit. The monitor compares strobes in order against a queue of expected writes. Register outputs are sampled only after the select line has been raised, at least eight cycles past the last byte.

// File: rtl/vfd_cmd_pkg.sv
package vfd_cmd_pkg;

  typedef enum logic [3:0] {
    OP_CCODE  = 4'h1,
    OP_GLYPH  = 4'h2,
    OP_SYM    = 4'h3,
    OP_PORT   = 4'h4,
    OP_DUTY   = 4'h5,
    OP_DIGITS = 4'h6,
    OP_LIGHT  = 4'h7,
    OP_TEST   = 4'h8
  } opcode_e;

  typedef enum logic [1:0] {
    MODE_CMD,
    MODE_CCODE,
    MODE_GLYPH,
    MODE_SYM
  } mode_e;

  localparam logic [1:0] LIGHT_RST = 2'b01;

endpackage

// File: rtl/vfd_serial_rx.sv
module vfd_serial_rx #(
  parameter  int SYNC_STAGES = 2,
  parameter  int BYTE_W      = 8,
  localparam int CNT_W       = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              frame_end_o
);

  logic [SYNC_STAGES-1:0] cs_sync, sclk_sync, sdat_sync;
  logic                   cs_s, sclk_s, sdat_s;
  logic                   cs_q, sclk_q;
  logic                   cs_rise, sclk_rise;
  logic [BYTE_W-1:0]      shreg, shift_nxt;
  logic [CNT_W-1:0]       cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync   <= '1;
      sclk_sync <= '1;
      sdat_sync <= '0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_ni};
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
      sdat_sync <= {sdat_sync[SYNC_STAGES-2:0], sdat_i};
    end
  end

  assign cs_s      = cs_sync[SYNC_STAGES-1];
  assign sclk_s    = sclk_sync[SYNC_STAGES-1];
  assign sdat_s    = sdat_sync[SYNC_STAGES-1];
  assign cs_rise   = cs_s & ~cs_q;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign shift_nxt = {sdat_s, shreg[BYTE_W-1:1]};  // LSB first
  assign byte_o    = shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q        <= 1'b1;
      sclk_q      <= 1'b1;
      shreg       <= '0;
      cnt         <= '0;
      byte_vld_o  <= 1'b0;
      frame_end_o <= 1'b0;
    end else begin
      cs_q        <= cs_s;
      sclk_q      <= sclk_s;
      byte_vld_o  <= 1'b0;
      frame_end_o <= 1'b0;
      if (cs_s) begin
        cnt         <= '0;  // partial byte dropped
        frame_end_o <= cs_rise && (cnt == '0);
      end else if (sclk_rise) begin
        shreg <= shift_nxt;
        if (cnt == CNT_W'(BYTE_W - 1)) begin
          cnt        <= '0;
          byte_vld_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vfd_cmd_fsm.sv
module vfd_cmd_fsm
  import vfd_cmd_pkg::*;
#(
  parameter  int CC_DEPTH    = 16,
  parameter  int GLYPH_DEPTH = 8,
  parameter  int SYM_DEPTH   = 16,
  parameter  int GLYPH_COLS  = 5,
  parameter  int GLYPH_ROWS  = 7,
  parameter  int SYM_W       = 2,
  localparam int CC_AW       = $clog2(CC_DEPTH),
  localparam int GL_AW       = $clog2(GLYPH_DEPTH),
  localparam int SYM_AW      = $clog2(SYM_DEPTH),
  localparam int COL_W       = $clog2(GLYPH_COLS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  byte_vld_i,
  input  logic [7:0]            byte_i,
  input  logic                  frame_end_i,
  output logic                  ccode_we_o,
  output logic [CC_AW-1:0]      ccode_addr_o,
  output logic [7:0]            ccode_data_o,
  output logic                  glyph_we_o,
  output logic [GL_AW-1:0]      glyph_addr_o,
  output logic [COL_W-1:0]      glyph_col_o,
  output logic [GLYPH_ROWS-1:0] glyph_data_o,
  output logic                  sym_we_o,
  output logic [SYM_AW-1:0]     sym_addr_o,
  output logic [SYM_W-1:0]      sym_data_o,
  output logic [1:0]            port_o,
  output logic [2:0]            duty_o,
  output logic [2:0]            digits_o,
  output logic [1:0]            light_o,
  output logic                  test_o
);

  mode_e             mode_q;
  logic [CC_AW-1:0]  cc_addr_q;
  logic [GL_AW-1:0]  gl_addr_q;
  logic [SYM_AW-1:0] sym_addr_q;
  logic [COL_W-1:0]  col_q;
  logic [3:0]        op;

  assign op = byte_i[7:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= MODE_CMD;
      cc_addr_q    <= '0;
      gl_addr_q    <= '0;
      sym_addr_q   <= '0;
      col_q        <= '0;
      ccode_we_o   <= 1'b0;
      ccode_addr_o <= '0;
      ccode_data_o <= '0;
      glyph_we_o   <= 1'b0;
      glyph_addr_o <= '0;
      glyph_col_o  <= '0;
      glyph_data_o <= '0;
      sym_we_o     <= 1'b0;
      sym_addr_o   <= '0;
      sym_data_o   <= '0;
      port_o       <= '0;
      duty_o       <= '0;
      digits_o     <= '0;
      light_o      <= LIGHT_RST;
      test_o       <= 1'b1;
    end else begin
      ccode_we_o <= 1'b0;
      glyph_we_o <= 1'b0;
      sym_we_o   <= 1'b0;
      if (byte_vld_i) begin
        case (mode_q)
          MODE_CCODE: begin
            ccode_we_o   <= 1'b1;
            ccode_addr_o <= cc_addr_q;
            ccode_data_o <= byte_i;
            cc_addr_q    <= cc_addr_q + 1'b1;
          end
          MODE_SYM: begin
            sym_we_o   <= 1'b1;
            sym_addr_o <= sym_addr_q;
            sym_data_o <= byte_i[SYM_W-1:0];
            sym_addr_q <= sym_addr_q + 1'b1;
          end
          MODE_GLYPH: begin
            glyph_we_o   <= 1'b1;
            glyph_addr_o <= gl_addr_q;
            glyph_col_o  <= col_q;
            glyph_data_o <= byte_i[GLYPH_ROWS-1:0];
            if (col_q == COL_W'(GLYPH_COLS - 1)) begin
              col_q     <= '0;
              gl_addr_q <= gl_addr_q + 1'b1;
            end else begin
              col_q <= col_q + 1'b1;
            end
          end
          default: begin
            case (op)
              OP_CCODE: begin
                mode_q    <= MODE_CCODE;
                cc_addr_q <= byte_i[CC_AW-1:0];
              end
              OP_GLYPH: begin
                mode_q    <= MODE_GLYPH;
                gl_addr_q <= byte_i[GL_AW-1:0];
                col_q     <= '0;
              end
              OP_SYM: begin
                mode_q     <= MODE_SYM;
                sym_addr_q <= byte_i[SYM_AW-1:0];
              end
              OP_PORT:   port_o   <= byte_i[1:0];
              OP_DUTY:   duty_o   <= byte_i[2:0];
              OP_DIGITS: digits_o <= byte_i[2:0];
              OP_LIGHT:  light_o  <= byte_i[1:0];
              OP_TEST:   if (byte_i[2:0] == 3'b000) test_o <= 1'b0;
              default: ;
            endcase
          end
        endcase
      end else if (frame_end_i) begin
        mode_q <= MODE_CMD;
        col_q  <= '0;
      end
    end
  end

endmodule

// File: rtl/vfd_cmd_decoder.sv
module vfd_cmd_decoder #(
  parameter  int SYNC_STAGES = 2,
  parameter  int CC_DEPTH    = 16,
  parameter  int GLYPH_DEPTH = 8,
  parameter  int SYM_DEPTH   = 16,
  parameter  int GLYPH_COLS  = 5,
  parameter  int GLYPH_ROWS  = 7,
  parameter  int SYM_W       = 2,
  localparam int CC_AW       = $clog2(CC_DEPTH),
  localparam int GL_AW       = $clog2(GLYPH_DEPTH),
  localparam int SYM_AW      = $clog2(SYM_DEPTH),
  localparam int COL_W       = $clog2(GLYPH_COLS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  sclk_i,
  input  logic                  sdat_i,
  output logic                  ccode_we_o,
  output logic [CC_AW-1:0]      ccode_addr_o,
  output logic [7:0]            ccode_data_o,
  output logic                  glyph_we_o,
  output logic [GL_AW-1:0]      glyph_addr_o,
  output logic [COL_W-1:0]      glyph_col_o,
  output logic [GLYPH_ROWS-1:0] glyph_data_o,
  output logic                  sym_we_o,
  output logic [SYM_AW-1:0]     sym_addr_o,
  output logic [SYM_W-1:0]      sym_data_o,
  output logic [1:0]            port_o,
  output logic [2:0]            duty_o,
  output logic [2:0]            digits_o,
  output logic [1:0]            light_o,
  output logic                  test_o
);

  logic       byte_vld;
  logic [7:0] rx_byte;
  logic       frame_end;

  vfd_serial_rx #(
    .SYNC_STAGES (SYNC_STAGES),
    .BYTE_W      (8)
  ) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sclk_i      (sclk_i),
    .sdat_i      (sdat_i),
    .byte_vld_o  (byte_vld),
    .byte_o      (rx_byte),
    .frame_end_o (frame_end)
  );

  vfd_cmd_fsm #(
    .CC_DEPTH    (CC_DEPTH),
    .GLYPH_DEPTH (GLYPH_DEPTH),
    .SYM_DEPTH   (SYM_DEPTH),
    .GLYPH_COLS  (GLYPH_COLS),
    .GLYPH_ROWS  (GLYPH_ROWS),
    .SYM_W       (SYM_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_vld_i   (byte_vld),
    .byte_i       (rx_byte),
    .frame_end_i  (frame_end),
    .ccode_we_o   (ccode_we_o),
    .ccode_addr_o (ccode_addr_o),
    .ccode_data_o (ccode_data_o),
    .glyph_we_o   (glyph_we_o),
    .glyph_addr_o (glyph_addr_o),
    .glyph_col_o  (glyph_col_o),
    .glyph_data_o (glyph_data_o),
    .sym_we_o     (sym_we_o),
    .sym_addr_o   (sym_addr_o),
    .sym_data_o   (sym_data_o),
    .port_o       (port_o),
    .duty_o       (duty_o),
    .digits_o     (digits_o),
    .light_o      (light_o),
    .test_o       (test_o)
  );

endmodule

// File: rtl/vfd_cmd_decoder_chk.sv
module vfd_cmd_decoder_chk #(
  parameter  int GLYPH_COLS = 5,
  localparam int COL_W      = $clog2(GLYPH_COLS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_vld,
  input logic             ccode_we_o,
  input logic             glyph_we_o,
  input logic             sym_we_o,
  input logic [COL_W-1:0] glyph_col_o,
  input logic [1:0]       port_o,
  input logic [2:0]       duty_o,
  input logic [2:0]       digits_o,
  input logic [1:0]       light_o,
  input logic             test_o
);

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ccode_we_o, glyph_we_o, sym_we_o}));  // R12

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccode_we_o | glyph_we_o | sym_we_o) |=> !(ccode_we_o | glyph_we_o | sym_we_o));  // R12

  AST_GLYPH_COL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glyph_we_o |-> (glyph_col_o < COL_W'(GLYPH_COLS)));  // R4

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(byte_vld) |-> $stable({port_o, duty_o, digits_o, light_o, test_o}));  // R9

  AST_RESET_VALUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (port_o == 2'b00 && duty_o == 3'd0 && digits_o == 3'd0
                       && light_o == 2'b01 && test_o));  // R10

endmodule

bind vfd_cmd_decoder vfd_cmd_decoder_chk #(.GLYPH_COLS(GLYPH_COLS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_vld    (byte_vld),
  .ccode_we_o  (ccode_we_o),
  .glyph_we_o  (glyph_we_o),
  .sym_we_o    (sym_we_o),
  .glyph_col_o (glyph_col_o),
  .port_o      (port_o),
  .duty_o      (duty_o),
  .digits_o    (digits_o),
  .light_o     (light_o),
  .test_o      (test_o)
);

// File: tb/vfd_cmd_decoder_tb.sv
module vfd_cmd_decoder_tb;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdat;
  logic       ccode_we, glyph_we, sym_we;
  logic [3:0] ccode_addr, sym_addr;
  logic [7:0] ccode_data;
  logic [2:0] glyph_addr, glyph_col, duty, digits;
  logic [6:0] glyph_data;
  logic [1:0] sym_data, port, light;
  logic       test;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    int         kind;  // 0 ccode, 1 glyph, 2 symbol
    logic [3:0] addr;
    logic [7:0] data;
    logic [2:0] col;
    string      req;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  vfd_cmd_decoder u_dut (
    .clk_i (clk), .rst_ni (rst_n), .cs_ni (cs_n), .sclk_i (sclk), .sdat_i (sdat),
    .ccode_we_o (ccode_we), .ccode_addr_o (ccode_addr), .ccode_data_o (ccode_data),
    .glyph_we_o (glyph_we), .glyph_addr_o (glyph_addr), .glyph_col_o (glyph_col),
    .glyph_data_o (glyph_data), .sym_we_o (sym_we), .sym_addr_o (sym_addr),
    .sym_data_o (sym_data), .port_o (port), .duty_o (duty), .digits_o (digits),
    .light_o (light), .test_o (test)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(int kind, logic [3:0] addr, logic [7:0] data, logic [2:0] col, string req);
    exp_t e;
    e.kind = kind; e.addr = addr; e.data = data; e.col = col; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (ccode_we || glyph_we || sym_we)) begin
      exp_t e;
      logic [31:0] act;
      int kind;
      kind = ccode_we ? 0 : (glyph_we ? 1 : 2);
      if (kind == 0) act = {12'd0, ccode_addr, ccode_data, 8'd0};
      else if (kind == 1) act = {12'd0, 1'b0, glyph_addr, 1'b0, glyph_data, 5'd0, glyph_col};
      else act = {12'd0, sym_addr, 6'd0, sym_data, 8'd0};
      if (exp_q.size() == 0) begin
        check("R12 unexpected strobe", act, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ex;
        e = exp_q.pop_front();
        if (e.kind == 0) ex = {12'd0, e.addr, e.data, 8'd0};
        else if (e.kind == 1) ex = {12'd0, e.addr, e.data, 5'd0, e.col};
        else ex = {12'd0, e.addr, e.data, 8'd0};
        check(e.req, {act[31:28], act[27:0]} + (kind != e.kind ? 32'h1000_0000 : 0), ex);
      end
    end
  end

  task automatic sbit(bit b);
    @(negedge clk);
    sclk = 1'b0;
    sdat = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) sbit(b[i]);
  endtask

  task automatic sel_low;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic sel_high;
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdat = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 port", port, 0);
    check("R10 duty", duty, 0);
    check("R10 digits", digits, 0);
    check("R10 light", light, 2'b01);
    check("R10 test", test, 1);
    check("R10 strobes", {ccode_we, glyph_we, sym_we}, 0);

    // R2 character codes with wrap
    push(0, 4'hE, 8'hA5, 0, "R2 ccode addr14");
    push(0, 4'hF, 8'h3C, 0, "R2 ccode addr15");
    push(0, 4'h0, 8'hFF, 0, "R2 ccode wrap");
    sel_low; send_byte(8'h1E); send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF); sel_high;

    // R3 symbols keep bits 1..0, wrap
    push(2, 4'hF, 8'h02, 0, "R3 sym addr15");
    push(2, 4'h0, 8'h01, 0, "R3 sym wrap");
    sel_low; send_byte(8'h3F); send_byte(8'hFE); send_byte(8'h01); sel_high;

    // R4 glyph columns, bit 7 dropped, address wrap 7->0
    for (int c = 0; c < 5; c++) push(1, 4'd7, 8'h7F & (8'h81 + 8'(c)), 3'(c), "R4 glyph addr7");
    for (int c = 0; c < 5; c++) push(1, 4'd0, 8'h7F & (8'h10 + 8'(c)), 3'(c), "R4 glyph addr0");
    sel_low; send_byte(8'h27);
    for (int c = 0; c < 5; c++) send_byte(8'h81 + 8'(c));
    for (int c = 0; c < 5; c++) send_byte(8'h10 + 8'(c));
    sel_high;

    // R5 R6 R7 control registers in one transfer
    sel_low; send_byte(8'h43); send_byte(8'h55); send_byte(8'h6A); send_byte(8'h72); sel_high;
    check("R5 port", port, 2'b11);
    check("R6 duty", duty, 3'd5);
    check("R6 digits bit3 ignored", digits, 3'd2);
    check("R7 light", light, 2'b10);
    check("R8 no data mode after control", exp_q.size(), 0);

    // R8 test flag
    sel_low; send_byte(8'h81); sel_high;
    check("R8 test kept", test, 1);
    sel_low; send_byte(8'h88); sel_high;
    check("R8 test cleared", test, 0);

    // R9 unlisted opcodes then a command in the same transfer
    sel_low; send_byte(8'h90); send_byte(8'h00); send_byte(8'hF3);
    sel_high;
    check("R9 duty unchanged", duty, 3'd5);
    check("R9 port unchanged", port, 2'b11);
    sel_low; send_byte(8'hA0); send_byte(8'h52); sel_high;
    check("R9 still command mode", duty, 3'd2);

    // R11 partial byte keeps mode, boundary rise returns to command
    push(0, 4'h0, 8'h11, 0, "R11 before partial");
    push(0, 4'h1, 8'h22, 0, "R11 after partial");
    sel_low; send_byte(8'h10); send_byte(8'h11);
    for (int i = 0; i < 4; i++) sbit(1'b1);
    sel_high;
    sel_low; send_byte(8'h22); sel_high;
    sel_low; send_byte(8'h41); sel_high;
    check("R11 boundary back to command", port, 2'b01);

    // R1 shift clock ignored while select high
    send_byte(8'h57);
    repeat (10) @(negedge clk);
    check("R1 ignored while deselected", duty, 3'd2);

    repeat (20) @(negedge clk);
    check("R12 all strobes seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule